// File: doc/BRIEF.md
# Keyed System Control Register File

This block is a bank of 32-bit control and identity registers on a simple word-addressed bus. The bus has a valid strobe, a write flag, a word address and write data. Each word holds 32 bits with bit 0 as the least significant bit, and every access is one whole aligned word.

Software must first write a magic value to the key register at word 0. Until it does, writes to the protected control registers are refused and flagged. The hardware strap word is loaded from the strap pins during reset. After that, software can only set its bits through the strap address and can only clear them through the revision address. The revision value itself never changes.

Identity and status words cannot be written. These are the two chip-identity constants, the frequency-counter result, the scratch words, the random-data word and the two halves of the free-running counter. Writes to them, writes beyond the implemented range and writes refused by the lock each raise their own one-cycle error pulse. A read returns its data one cycle after the request.

Top module: `sysctl_keyed_regs`

Word map (word index, with byte offset = 4 × index):

| Word index | Byte offset | Register | Access |
|---|---|---|---|
| 0 | 0x000 | Key | read/write, never locked |
| 1 | 0x004 | Revision | read `rev_id`; a write clears strap bits |
| 2 | 0x008 | Strap | read/write; a write sets bits |
| 3 | 0x00C | Frequency-counter result | read-only |
| 4..11 | 0x010..0x02C | Scratch | read-only, read 0 |
| 12 | 0x030 | Random data | read-only |
| 13, 14 | 0x034, 0x038 | Free-running counter, low and high half | read-only |
| 16..23 | 0x040..0x05C | Configuration | read/write |
| 0x54, 0x55 | 0x150, 0x154 | Chip identity 0 and 1 | read-only |
| 64 (0x40) and up | 0x100 and up | Boundary of the protected range | — |
| 128 (0x80) and up | 0x200 and up | Out of bounds | — |

## Requirements
- R1: After a synchronous active-low reset, the following values hold. Key reads 0. Strap reads the value on `strap_pins` during reset. Configuration word i (word index 16+i, i = 0..7) reads 0x00000100+i. Chip-identity words read their fixed values. All error outputs and `bus_rvalid` are low.
- R2: A write to word 0 stores 1 if the data equals the key parameter (default 0x1688A8A8) and stores 0 for any other data. Reading word 0 returns the stored bit in bit 0, with zeros elsewhere. Writes to word 0 are never locked.
- R3: An accepted write to word 2 ORs the write data into the strap word.
- R4: An accepted write to word 1 clears every strap bit that is 1 in the data. Word 1 always reads `rev_id`.
- R5: Word 0x54 (byte offset 0x150) reads 0x1234ABCD and word 0x55 (byte offset 0x154) reads 0x88884444. Writes to them are discarded and pulse `err_ro`.
- R6: The read-only words return the following. Word 3 returns `freq_result`. Words 4..11 return 0. Word 12 returns `rng_data`. Words 13 and 14 return `free_cnt[31:0]` and `free_cnt[63:32]`. Writes to any of them are discarded and pulse `err_ro`.
- R7: A write to word index 128 or above is discarded and pulses `err_oob`. A read there returns 0.
- R8: While the key reads 0, writes to words 1, 2 and 16..23 are discarded and pulse `err_lock`.
- R9: While the key reads 1, configuration words 16..23 store and return the written data.
- R10: Read data and `bus_rvalid` appear in the cycle after the read request, and `bus_rdata` is 0 in cycles with no read. Each error output goes high for one cycle, in the cycle after the write. At most one error is raised per write, with priority out-of-bounds, then read-only, then locked.
- R11: Writes to unmapped words below 128 change nothing and raise no error. Reads of those words return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_valid | input | 1 | Access request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 9 | Word index |
| bus_wdata | input | 32 | Write data |
| strap_pins | input | 32 | Strap value loaded during reset |
| rev_id | input | 32 | Silicon revision value |
| freq_result | input | 32 | Frequency-counter result |
| rng_data | input | 32 | Random data value |
| free_cnt | input | 64 | Free-running counter value |
| bus_rdata | output | 32 | Read data, one cycle after the request |
| bus_rvalid | output | 1 | Read data valid |
| err_oob | output | 1 | Out-of-bounds write pulse |
| err_ro | output | 1 | Read-only write pulse |
| err_lock | output | 1 | Locked write pulse |

## Verification
The hardest states to reach are these:
- a write refused by the lock after the key has been cleared again partway through a run;
- a strap clear through the revision address landing just after a set;
- a write aimed at a read-only word inside the protected range while the bank is locked, where the read-only error must win over the lock error.

The stimulus reaches them in three ways:
- scripted phases that lock, unlock and relock the bank, each write followed by a read-back;
- a long pseudo-random phase that often rewrites the key with right and wrong values, mixing protected, read-only, hole and out-of-range addresses;
- changes to the status inputs partway through the run.

A behavioural model in the bench predicts every output on every clock.

// File: rtl/sysctl_pkg.sv
// Package: shared word indices, identity constants and the address class
// type for the keyed system control register file.
package sysctl_pkg;
    localparam int IDX_KEY    = 0;
    localparam int IDX_REV    = 1;
    localparam int IDX_STRAP  = 2;
    localparam int IDX_FREQ   = 3;
    localparam int IDX_SCR_LO = 4;
    localparam int IDX_SCR_HI = 11;
    localparam int IDX_RNG    = 12;
    localparam int IDX_CNT_LO = 13;
    localparam int IDX_CNT_HI = 14;
    localparam int IDX_ID0    = 'h54;
    localparam int IDX_ID1    = 'h55;
    localparam logic [31:0] ID0_VALUE = 32'h1234ABCD;
    localparam logic [31:0] ID1_VALUE = 32'h88884444;

    typedef enum logic [3:0] {
        CL_KEY, CL_REV, CL_STRAP, CL_RO_IN, CL_RO_ZERO,
        CL_ID, CL_CFG, CL_HOLE, CL_OOB
    } addr_cls_e;
endpackage

// File: rtl/sysctl_decode.sv
// Address decoder: classifies a word index into a register class and gives
// the configuration slot index. Purely combinational.
// Assumes CFG_BASE+NUM_CFG does not overlap the fixed words in sysctl_pkg.
module sysctl_decode
    import sysctl_pkg::*;
#(
    parameter int ADDR_W   = 9,
    parameter int NUM_REGS = 128,
    parameter int CFG_BASE = 16,
    parameter int NUM_CFG  = 8,
    localparam int CIDX_W  = (NUM_CFG > 1) ? $clog2(NUM_CFG) : 1
) (
    input  logic [ADDR_W-1:0] addr,
    output addr_cls_e         cls,
    output logic [CIDX_W-1:0] cfg_idx
);
    logic [31:0] a;
    assign a = 32'(addr);

    // Classify the word index.
    always_comb begin
        cls = CL_HOLE;
        if (a >= 32'(NUM_REGS))                                  cls = CL_OOB;
        else if (a == 32'(IDX_KEY))                              cls = CL_KEY;
        else if (a == 32'(IDX_REV))                              cls = CL_REV;
        else if (a == 32'(IDX_STRAP))                            cls = CL_STRAP;
        else if (a == 32'(IDX_FREQ) || a == 32'(IDX_RNG) ||
                 a == 32'(IDX_CNT_LO) || a == 32'(IDX_CNT_HI))   cls = CL_RO_IN;
        else if (a >= 32'(IDX_SCR_LO) && a <= 32'(IDX_SCR_HI))   cls = CL_RO_ZERO;
        else if (a == 32'(IDX_ID0) || a == 32'(IDX_ID1))         cls = CL_ID;
        else if (a >= 32'(CFG_BASE) && a < 32'(CFG_BASE + NUM_CFG)) cls = CL_CFG;
    end

    assign cfg_idx = CIDX_W'(a - 32'(CFG_BASE));
endmodule

// File: rtl/sysctl_strap.sv
// Strap register: loads the strap pins while reset is held, then only sets
// bits on set_en and only clears bits on clr_en. Assumes the two enables
// are never asserted together.
module sysctl_strap #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pins,
    input  logic         set_en,
    input  logic         clr_en,
    input  logic [W-1:0] data,
    output logic [W-1:0] q
);
    // Strap storage with set-only and clear-only paths.
    always_ff @(posedge clk) begin
        if (!rst_n)      q <= pins;
        else if (set_en) q <= q | data;
        else if (clr_en) q <= q & ~data;
    end

    AST_STRAP_SET_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        set_en |=> ((q & $past(data)) == $past(data)) && ((q & $past(q)) == $past(q))); // R3
    AST_STRAP_CLR_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        clr_en |=> ((q & $past(data)) == '0) && ((q | $past(q)) == $past(q))); // R4
endmodule

// File: rtl/sysctl_cfg_bank.sv
// General configuration registers: NUM_CFG words, each with its own reset
// value RST_BASE+i, written when we is high and idx selects the word.
module sysctl_cfg_bank #(
    parameter int          NUM_CFG  = 8,
    parameter logic [31:0] RST_BASE = 32'h0000_0100,
    localparam int         CIDX_W   = (NUM_CFG > 1) ? $clog2(NUM_CFG) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    we,
    input  logic [CIDX_W-1:0]       idx,
    input  logic [31:0]             wdata,
    output logic [NUM_CFG-1:0][31:0] q
);
    for (genvar i = 0; i < NUM_CFG; i++) begin : g_word
        // One configuration word.
        always_ff @(posedge clk) begin
            if (!rst_n)                          q[i] <= RST_BASE + 32'(i);
            else if (we && idx == CIDX_W'(i))    q[i] <= wdata;
        end
    end

    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(q)); // R9
endmodule

// File: rtl/sysctl_keyed_regs.sv
// Keyed system control register file (top). Holds the key bit, ties the
// decoder, strap and configuration bank together, raises single-cycle error
// pulses and returns read data one cycle after the request.
// Assumes whole-word, aligned accesses on a word-indexed bus.
module sysctl_keyed_regs
    import sysctl_pkg::*;
#(
    parameter int          ADDR_W   = 9,
    parameter int          NUM_REGS = 128,
    parameter int          CFG_BASE = 16,
    parameter int          NUM_CFG  = 8,
    parameter int          PROT_END = 64,
    parameter logic [31:0] KEY      = 32'h1688A8A8,
    parameter logic [31:0] CFG_RST  = 32'h0000_0100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    input  logic [31:0]       strap_pins,
    input  logic [31:0]       rev_id,
    input  logic [31:0]       freq_result,
    input  logic [31:0]       rng_data,
    input  logic [63:0]       free_cnt,
    output logic [31:0]       bus_rdata,
    output logic              bus_rvalid,
    output logic              err_oob,
    output logic              err_ro,
    output logic              err_lock
);
    localparam int CIDX_W = (NUM_CFG > 1) ? $clog2(NUM_CFG) : 1;

    addr_cls_e                cls;
    logic [CIDX_W-1:0]        cfg_idx;
    logic                     key_q;
    logic [31:0]              strap_q;
    logic [NUM_CFG-1:0][31:0] cfg_q;
    logic [31:0]              a_w;
    logic                     wr, rd, prot_cls, ro_cls, wr_ok;
    logic [31:0]              rd_word;

    assign a_w      = 32'(bus_addr);
    assign wr       = bus_valid && bus_write;
    assign rd       = bus_valid && !bus_write;
    assign prot_cls = (cls == CL_REV) || (cls == CL_STRAP) || (cls == CL_CFG);
    assign ro_cls   = (cls == CL_ID) || (cls == CL_RO_IN) || (cls == CL_RO_ZERO);
    assign wr_ok    = wr && key_q && prot_cls;

    sysctl_decode #(
        .ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS), .CFG_BASE(CFG_BASE), .NUM_CFG(NUM_CFG)
    ) u_dec (
        .addr(bus_addr), .cls(cls), .cfg_idx(cfg_idx)
    );

    sysctl_strap #(.W(32)) u_strap (
        .clk(clk), .rst_n(rst_n), .pins(strap_pins),
        .set_en(wr_ok && cls == CL_STRAP), .clr_en(wr_ok && cls == CL_REV),
        .data(bus_wdata), .q(strap_q)
    );

    sysctl_cfg_bank #(.NUM_CFG(NUM_CFG), .RST_BASE(CFG_RST)) u_cfg (
        .clk(clk), .rst_n(rst_n), .we(wr_ok && cls == CL_CFG),
        .idx(cfg_idx), .wdata(bus_wdata), .q(cfg_q)
    );

    // Key bit: set only by the exact magic value, never locked.
    always_ff @(posedge clk) begin
        if (!rst_n)                     key_q <= 1'b0;
        else if (wr && cls == CL_KEY)   key_q <= (bus_wdata == KEY);
    end

    // Read multiplexer over the register classes.
    always_comb begin
        rd_word = '0;
        case (cls)
            CL_KEY:   rd_word = {31'b0, key_q};
            CL_REV:   rd_word = rev_id;
            CL_STRAP: rd_word = strap_q;
            CL_RO_IN: begin
                if (a_w == 32'(IDX_FREQ))        rd_word = freq_result;
                else if (a_w == 32'(IDX_RNG))    rd_word = rng_data;
                else if (a_w == 32'(IDX_CNT_LO)) rd_word = free_cnt[31:0];
                else                             rd_word = free_cnt[63:32];
            end
            CL_ID:    rd_word = (a_w == 32'(IDX_ID0)) ? ID0_VALUE : ID1_VALUE;
            CL_CFG:   rd_word = cfg_q[cfg_idx];
            default:  rd_word = '0;
        endcase
    end

    // Registered read response and prioritised error pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata  <= '0;
            bus_rvalid <= 1'b0;
            err_oob    <= 1'b0;
            err_ro     <= 1'b0;
            err_lock   <= 1'b0;
        end else begin
            bus_rdata  <= rd ? rd_word : '0;
            bus_rvalid <= rd;
            err_oob    <= wr && (cls == CL_OOB);
            err_ro     <= wr && ro_cls;
            err_lock   <= wr && prot_cls && !key_q;
        end
    end

    AST_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({err_oob, err_ro, err_lock})); // R10
    AST_RD_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        rd |=> bus_rvalid); // R10
    AST_KEY_WRONG: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && a_w == 32'(IDX_KEY) && bus_wdata != KEY) |=> !key_q); // R2
    AST_LOCKED_STRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !key_q && a_w == 32'(IDX_STRAP)) |=> ($stable(strap_q) && err_lock)); // R8
    AST_OOB_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && a_w >= 32'(NUM_REGS)) |=> err_oob); // R7
    AST_PROT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && a_w >= 32'(PROT_END)) |=> !err_lock); // R8
endmodule

// File: tb/sim_sysctl_keyed_regs.sv
// Bench: behavioural reference model updated on every clock edge and
// compared with all outputs at each falling edge.
module sim_sysctl_keyed_regs;
    localparam logic [31:0] KEYV = 32'h1688A8A8;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        bus_valid, bus_write;
    logic [8:0]  bus_addr;
    logic [31:0] bus_wdata, strap_pins, rev_id, freq_result, rng_data;
    logic [63:0] free_cnt;
    logic [31:0] bus_rdata;
    logic        bus_rvalid, err_oob, err_ro, err_lock;

    always #10 clk = ~clk;

    sysctl_keyed_regs u0 (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .strap_pins(strap_pins),
        .rev_id(rev_id), .freq_result(freq_result), .rng_data(rng_data),
        .free_cnt(free_cnt), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
        .err_oob(err_oob), .err_ro(err_ro), .err_lock(err_lock)
    );

    int checks = 0, failures = 0, cyc = 0;
    bit [31:0] m_key, m_strap;
    bit [31:0] m_cfg [8];
    bit        m_fresh, m_live = 0;
    bit [31:0] e_rdata;
    bit        e_rv, e_oob, e_ro, e_lock;
    string     tag_rd = "R1", tag_wr = "R1";

    function automatic bit [31:0] m_read(int a);
        if (a >= 128) return 0;                        // R7
        case (a)
            0: return m_key;
            1: return rev_id;
            2: return m_strap;
            3: return freq_result;
            12: return rng_data;
            13: return free_cnt[31:0];
            14: return free_cnt[63:32];
            'h54: return 32'h1234ABCD;                 // R5
            'h55: return 32'h88884444;
            default: begin
                if (a >= 16 && a < 24) return m_cfg[a-16];
                return 0;                              // scratch and holes
            end
        endcase
    endfunction

    function automatic string cls_tag(int a);
        if (a >= 128) return "R7";
        if (a == 0) return "R2";
        if (a == 1) return "R4";
        if (a == 2) return "R3";
        if (a == 'h54 || a == 'h55) return "R5";
        if (a >= 3 && a <= 14) return "R6";
        if (a >= 16 && a < 24) return "R9";
        return "R11";
    endfunction

    // Reference model: state and expected registered outputs.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_key = 0; m_strap = strap_pins;
            for (int i = 0; i < 8; i++) m_cfg[i] = 32'h100 + i;
            e_rdata = 0; e_rv = 0; e_oob = 0; e_ro = 0; e_lock = 0;
            m_fresh = 1; m_live = 1; tag_rd = "R1"; tag_wr = "R1";
        end else begin
            int a;
            a = int'(bus_addr);
            e_rv = 0; e_rdata = 0; e_oob = 0; e_ro = 0; e_lock = 0;
            tag_wr = m_fresh ? "R1" : "R10";
            if (bus_valid && !bus_write) begin
                e_rv = 1; e_rdata = m_read(a);
                tag_rd = m_fresh ? "R1" : cls_tag(a);
            end
            if (bus_valid && bus_write) begin
                m_fresh = 0;
                tag_wr = cls_tag(a);
                if (a >= 128) e_oob = 1;
                else if (a == 'h54 || a == 'h55 || (a >= 3 && a <= 14)) e_ro = 1;
                else if (a == 0) m_key = (bus_wdata == KEYV) ? 1 : 0;
                else if (a == 1 || a == 2 || (a >= 16 && a < 24)) begin
                    if (m_key == 0) begin e_lock = 1; tag_wr = "R8"; end
                    else if (a == 1) m_strap = m_strap & ~bus_wdata;
                    else if (a == 2) m_strap = m_strap | bus_wdata;
                    else m_cfg[a-16] = bus_wdata;
                end
            end
        end
    end

    task automatic chk(string req, string what, bit [31:0] act, bit [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h t=%0t", req, what, act, exp, $time);
        end
    endtask

    // Compare every output away from the active edge.
    always @(negedge clk) begin
        if (m_live) begin
            chk("R10", "rvalid", 32'(bus_rvalid), 32'(e_rv));
            chk(e_rv ? tag_rd : "R10", "rdata", bus_rdata, e_rdata);
            chk(tag_wr, "err_oob", 32'(err_oob), 32'(e_oob));
            chk(tag_wr, "err_ro", 32'(err_ro), 32'(e_ro));
            chk(tag_wr, "err_lock", 32'(err_lock), 32'(e_lock));
        end
    end

    // Watchdog: a hung run is a failed check.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            failures++;
            $display("FAIL R10 watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic op(bit w, int a, bit [31:0] d);
        @(negedge clk);
        bus_valid = 1; bus_write = w; bus_addr = a[8:0]; bus_wdata = d;
    endtask

    task automatic wr_rd(int a, bit [31:0] d);
        op(1, a, d);
        op(0, a, 0);
    endtask

    bit [31:0] s = 32'h2545F491;
    function automatic bit [31:0] nxt(bit [31:0] x);
        x ^= x << 13; x ^= x >> 17; x ^= x << 5;
        return x;
    endfunction

    initial begin
        rst_n = 0; bus_valid = 0; bus_write = 0; bus_addr = 0; bus_wdata = 0;
        strap_pins = 32'h0000_00A5; rev_id = 32'h0403_0303;
        freq_result = 32'h0000_1234; rng_data = 32'hCAFE_0001;
        free_cnt = 64'h0000_0007_8000_0001;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: reset contents of every word, plus out-of-range reads (R7).
        for (int a = 0; a < 130; a++) op(0, a, 0);
        op(0, 'h1FF, 0);
        // R8: writes while locked, including R11 holes and R6/R5 precedence.
        wr_rd(2, 32'hFFFF_0000); wr_rd(1, 32'h0000_00FF); wr_rd(16, 32'hDEAD_BEEF);
        wr_rd(3, 32'h1); wr_rd('h54, 32'h0); wr_rd(32, 32'h55); wr_rd(15, 32'h77);
        // R2: wrong key keeps lock, right key unlocks.
        wr_rd(0, KEYV ^ 32'h1); wr_rd(0, KEYV);
        // R3/R4: set then clear strap bits; revision unchanged.
        wr_rd(2, 32'h0F00_0000); wr_rd(1, 32'h0000_0005); wr_rd(2, 32'h0000_0001);
        // R9: config words.
        for (int i = 0; i < 8; i++) wr_rd(16 + i, 32'hA5A5_0000 + i);
        // R5/R6: read-only words stay put.
        wr_rd('h55, 32'hFFFF_FFFF); for (int a = 3; a <= 14; a++) wr_rd(a, 32'h1111_1111);
        // R7/R11: out of range and holes while unlocked.
        wr_rd(128, 32'h1); wr_rd('h1FF, 32'h2); wr_rd(64, 32'h3); wr_rd(100, 32'h4);
        // R8: relock and retry.
        wr_rd(0, 32'h0); wr_rd(17, 32'h0); wr_rd(2, 32'hFFFF_FFFF);
        // Change status inputs partway through the run (R4, R6).
        @(negedge clk); rev_id = 32'h0503_0303; freq_result = 32'h0000_9999;
        rng_data = 32'h1234_5678; free_cnt = 64'hFFFF_FFFF_0000_0002;
        for (int a = 1; a < 15; a++) op(0, a, 0);
        // Pseudo-random mix of all classes.
        for (int n = 0; n < 4000; n++) begin
            int a; bit w; bit [31:0] d;
            s = nxt(s); d = nxt(s);
            w = s[7];
            case (s[2:0])
                0: begin a = 0; if (s[9]) d = KEYV; end
                1: a = 1 + int'(s[8]);
                2: a = 16 + int'(s[10:8]);
                3: a = s[11] ? ('h54 + int'(s[8])) : (3 + int'(s[11:8]) % 12);
                4: a = int'(s[14:8]) ;
                default: a = s[12] ? 128 + int'(s[19:12]) % 384 : int'(s[15:9]) % 24;
            endcase
            op(w, a, d);
        end
        @(negedge clk); bus_valid = 0;
        repeat (3) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule